// File: doc/BRIEF.md
# Addressed Serial Frame Receiver

This block listens on one asynchronous serial line and picks out the frames meant for it. Each frame is eleven bits long: a low start bit, eight data bits sent least significant first, an even-parity bit and a high stop bit. Bit timing comes from the system clock alone. Once a start edge is seen, every bit lasts a fixed number of clock cycles and is sampled at the middle of its period.

The top data bit tells the two kinds of word apart. A word with that bit set carries a 7-bit station address. If the address equals the static address on `addr_i`, the block gives a one-cycle valid-address pulse and arms itself. The next complete word may then be a command word (top data bit clear). Its seven low bits are latched onto `cmd_o`, and a one-cycle command strobe is given. A word with bad parity, a low stop bit, or a command word that does not come straight after a matched address is ignored.

Top module: `frx_addr_rx`

## Requirements
- R1: With the default parameters one bit period is 64 clock cycles. Data bits arrive least significant first, and every bit is sampled at the middle of its period. A result pulse rises on the 675th rising clock edge after `rx_i` first goes low for the start bit: two synchroniser stages, one detection edge, then 10.5 bit periods.
- R2: A low level on `rx_i` that has returned high by the mid-point sample of the start bit is treated as noise. It produces no word, no pulse and no change to the armed state.
- R3: An address word has data bit 7 equal to 1, correct even parity and a high stop bit. When its data bits 6..0 equal `addr_i`, `vap_o` goes high for exactly one cycle, and the command latch is armed.
- R4: An address word whose bits differ from `addr_i` produces no `vap_o`. A word with data bit 7 equal to 0 never produces `vap_o`, whatever its low bits hold.
- R5: A word with odd parity over its eight data bits plus the parity bit is discarded. It produces no `vap_o` and no `cmd_stb_o`.
- R6: A word whose stop bit is sampled low is discarded as a framing error.
- R7: A valid command word (data bit 7 equal to 0) that is the first complete word after a matched address word loads its bits 6..0 onto `cmd_o`. In that same cycle `cmd_stb_o` goes high for exactly one clock cycle.
- R8: A command word is ignored if any other complete word came after the last matched address word, including a non-matching word, a discarded word or a command word. It is also ignored if no matched address word came before it. An ignored command word gives no strobe and leaves `cmd_o` unchanged.
- R9: `rst_ni` low clears `cmd_o`, `vap_o`, `cmd_stb_o` and the armed state, and abandons any frame in progress. Afterwards the receiver hunts for a fresh start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; bit timing is derived from it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idles high |
| addr_i | input | 7 | Static local station address |
| vap_o | output | 1 | One-cycle pulse on a matched address word |
| cmd_o | output | 7 | Latched command bits |
| cmd_stb_o | output | 1 | One-cycle pulse when `cmd_o` is loaded |

## Verification
Both result pulses fall due on a fixed rising edge: edge 675 after the bench drives the start bit low. The bench records the cycle counter at the moment it drives the start bit. A falling-edge monitor records the counter value and the number of cycles each pulse is high. Each frame's check then compares the pulse count to the expected count, and compares the recorded cycle to the start cycle plus 675. The latched command value is read only after the whole frame, including its stop bit, has been driven, which is well after the 675-edge point.

// File: rtl/frx_pkg.sv
package frx_pkg;
  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;
endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= 1'b1;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/frx_bit_timer.sv
module frx_bit_timer #(
  parameter int OSR = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic mid_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign mid_o = run_i && (cnt_q == MID);
endmodule

// File: rtl/frx_shift.sv
module frx_shift #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  // lsb-first line: newest bit enters at the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {bit_i, sh_q[W-1:1]};
  end

  assign word_o = sh_q;
endmodule

// File: rtl/frx_addr_rx.sv
module frx_addr_rx
  import frx_pkg::*;
#(
  parameter int OSR         = 64,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              vap_o,
  output logic [ADDR_W-1:0] cmd_o,
  output logic              cmd_stb_o
);
  localparam int DATA_W     = ADDR_W + 1;
  localparam int SH_W       = DATA_W + 1;
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(FRAME_BITS - 1);

  rx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              rx_s, mid, start_det, shift_en, done, glitch;
  logic [SH_W-1:0]   sh;
  logic [DATA_W-1:0] word;
  logic              frame_ok, is_addr, match, arm_next;
  logic              armed_q, vap_q, stb_q;
  logic [ADDR_W-1:0] cmd_q;

  frx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  assign start_det = (state_q == RX_HUNT) && !rx_s;

  frx_bit_timer #(.OSR(OSR)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(start_det),
    .run_i    (state_q == RX_RUN),
    .mid_o    (mid)
  );

  assign shift_en = mid && (idx_q != '0) && (idx_q != STOP_IDX);
  assign done     = mid && (idx_q == STOP_IDX);
  assign glitch   = mid && (idx_q == '0) && rx_s;

  frx_shift #(.W(SH_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (shift_en),
    .bit_i (rx_s),
    .word_o(sh)
  );

  assign word     = sh[DATA_W-1:0];
  assign frame_ok = rx_s && !(^sh);
  assign is_addr  = word[DATA_W-1];
  assign match    = (word[ADDR_W-1:0] == addr_i);
  assign arm_next = frame_ok && is_addr && match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_HUNT;
      idx_q   <= '0;
    end else if (start_det) begin
      state_q <= RX_RUN;
      idx_q   <= '0;
    end else if (glitch || done) begin
      state_q <= RX_HUNT;
      idx_q   <= '0;
    end else if (mid) begin
      idx_q   <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      vap_q   <= 1'b0;
      stb_q   <= 1'b0;
      cmd_q   <= '0;
    end else begin
      vap_q <= done && arm_next;
      stb_q <= done && frame_ok && !is_addr && armed_q;
      if (done) armed_q <= arm_next;
      if (done && frame_ok && !is_addr && armed_q) cmd_q <= word[ADDR_W-1:0];
    end
  end

  assign vap_o     = vap_q;
  assign cmd_stb_o = stb_q;
  assign cmd_o     = cmd_q;
endmodule

// File: rtl/frx_addr_rx_chk.sv
module frx_addr_rx_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vap_o,
  input logic              cmd_stb_o,
  input logic [ADDR_W-1:0] cmd_o,
  input logic              armed
);
  AST_VAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vap_o |=> !vap_o);                                    // R3
  AST_ARM_WITH_VAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed) |-> vap_o);                              // R3
  AST_TYPE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vap_o && cmd_stb_o));                               // R4
  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |=> !cmd_stb_o);                            // R7
  AST_STB_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |-> $past(armed));                          // R8
  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_stb_o |-> $stable(cmd_o));                       // R8
endmodule

bind frx_addr_rx frx_addr_rx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .vap_o    (vap_o),
  .cmd_stb_o(cmd_stb_o),
  .cmd_o    (cmd_o),
  .armed    (armed_q)
);

// File: tb/tb_frx_addr_rx.sv
module tb_frx_addr_rx;
  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 64;
  localparam int LAT        = 675;
  localparam int GAP        = 16;
  localparam logic [6:0] LOCAL_A = 7'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [6:0] addr = LOCAL_A;
  logic       vap, stb;
  logic [6:0] cmd;

  int cyc = 0, n_vec = 0, n_fail = 0;
  int vap_cnt = 0, stb_cnt = 0, vap_at = -1, stb_at = -1;
  logic [6:0] exp_cmd = '0;

  frx_addr_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .addr_i(addr),
    .vap_o(vap), .cmd_o(cmd), .cmd_stb_o(stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (vap) begin vap_cnt++; vap_at = cyc; end
    if (stb) begin stb_cnt++; stb_at = cyc; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx = b;
    repeat (OSR) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, input bit bad_par, input bit stop_v,
                      input bit exp_vap, input bit exp_stb, input string req);
    int v0, s0, t0;
    v0 = vap_cnt; s0 = stb_cnt;
    @(negedge clk);
    t0 = cyc;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit((^d) ^ bad_par);
    drive_bit(stop_v);
    rx = 1'b1;
    repeat (GAP) @(negedge clk);
    if (exp_stb) exp_cmd = d[6:0];
    chk(vap_cnt - v0 == int'(exp_vap), {req, " vap count"}, vap_cnt - v0, int'(exp_vap));
    if (exp_vap) chk(vap_at == t0 + LAT, "R1 vap timing", vap_at, t0 + LAT);
    chk(stb_cnt - s0 == int'(exp_stb), {req, " strobe count"}, stb_cnt - s0, int'(exp_stb));
    if (exp_stb) chk(stb_at == t0 + LAT, "R1 strobe timing", stb_at, t0 + LAT);
    chk(cmd == exp_cmd, {req, " cmd_o"}, int'(cmd), int'(exp_cmd));
  endtask

  function automatic logic [7:0] aw(input logic [6:0] a);
    return {1'b1, a};
  endfunction

  function automatic logic [7:0] cw(input logic [6:0] c);
    return {1'b0, c};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] cmds [6];
    int v0, s0;
    cmds = '{7'h00, 7'h7F, 7'h55, 7'h2A, 7'h01, 7'h40};
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(vap == 1'b0, "R9 vap reset", int'(vap), 0);
    chk(stb == 1'b0, "R9 stb reset", int'(stb), 0);
    chk(cmd == 7'h00, "R9 cmd reset", int'(cmd), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 / R4 address sweep
    for (int a = 0; a < 128; a++)
      xfer(aw(7'(a)), 1'b0, 1'b1, 7'(a) == LOCAL_A, 1'b0, (7'(a) == LOCAL_A) ? "R3" : "R4");

    // R8 command with no armed address
    xfer(cw(7'h33), 1'b0, 1'b1, 1'b0, 1'b0, "R8");

    // R7 matched address then command
    foreach (cmds[i]) begin
      xfer(aw(LOCAL_A), 1'b0, 1'b1, 1'b1, 1'b0, "R3");
      xfer(cw(cmds[i]), 1'b0, 1'b1, 1'b0, 1'b1, "R7");
    end

    // R4 command-type word carrying the local address bits
    xfer(cw(LOCAL_A), 1'b0, 1'b1, 1'b0, 1'b0, "R4");

    // R5 parity errors
    xfer(aw(LOCAL_A), 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    xfer(cw(7'h11), 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    xfer(aw(LOCAL_A), 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    xfer(cw(7'h22), 1'b1, 1'b1, 1'b0, 1'b0, "R5");

    // R6 framing errors
    xfer(aw(LOCAL_A), 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    xfer(cw(7'h0F), 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    xfer(aw(LOCAL_A), 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    xfer(cw(7'h70), 1'b0, 1'b0, 1'b0, 1'b0, "R6");

    // R2 start glitch
    v0 = vap_cnt; s0 = stb_cnt;
    @(negedge clk);
    rx = 1'b0;
    repeat (20) @(negedge clk);
    rx = 1'b1;
    repeat (120) @(negedge clk);
    chk(vap_cnt == v0, "R2 glitch vap", vap_cnt - v0, 0);
    chk(stb_cnt == s0, "R2 glitch stb", stb_cnt - s0, 0);
    xfer(aw(LOCAL_A), 1'b0, 1'b1, 1'b1, 1'b0, "R2");
    xfer(cw(7'h6C), 1'b0, 1'b1, 1'b0, 1'b1, "R2");

    // R7 re-arm, R8 intervening word
    xfer(aw(LOCAL_A), 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    xfer(aw(LOCAL_A), 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    xfer(cw(7'h19), 1'b0, 1'b1, 1'b0, 1'b1, "R7");
    xfer(aw(LOCAL_A), 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    xfer(aw(7'h5B), 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    xfer(cw(7'h44), 1'b0, 1'b1, 1'b0, 1'b0, "R8");

    // R3 new local address
    addr = 7'h03;
    xfer(aw(LOCAL_A), 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    xfer(aw(7'h03), 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    xfer(cw(7'h3C), 1'b0, 1'b1, 1'b0, 1'b1, "R7");

    // R9 reset mid-frame after arming
    xfer(aw(7'h03), 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    s0 = stb_cnt;
    @(negedge clk);
    rx = 1'b0;
    repeat (OSR * 5) @(negedge clk);
    rst_n = 1'b0;
    rx = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    exp_cmd = '0;
    repeat (800) @(negedge clk);
    chk(cmd == 7'h00, "R9 cmd cleared", int'(cmd), 0);
    chk(stb_cnt == s0, "R9 no strobe", stb_cnt - s0, 0);
    xfer(cw(7'h2D), 1'b0, 1'b1, 1'b0, 1'b0, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule